// File: doc/BRIEF.md
# TDM Synchronous Serial Port

This block is a synchronous serial port. A transmitter and a receiver share one bit clock and one frame-sync line, and both are generated inside the block by dividing the system clock. Parallel words enter through a single holding register with a valid/ready handshake. Each word is shifted out MSB first. Words arriving on the serial input are gathered into a parallel output that is held until it is accepted.

The port has two framing modes. In normal mode a frame holds one word in each direction. In network mode a frame holds between 2 and 32 time slots. A per-slot enable mask decides which of those slots take part in the transfer.

The bit clock either runs all the time, or is gated so that it toggles only around active words. Gating is only allowed in normal mode. If gating is requested together with network mode, the block keeps the clock running and reports a configuration error.

Top module: `tdm_serial_port`

## Requirements
- R1: Transmit and receive share `bclk` and `fsync`. `sdout` changes only on a rising edge of `bclk`, and `sdin` is sampled on its falling edge. A word received in an active slot appears on `rx_data` with `rx_valid` high.
- R2: In normal mode (`cfg_network`=0) every frame has exactly one slot, so `fsync` recurs every `wl` bit periods when the clock runs continuously.
- R3: In network mode a frame has `cfg_slots` slots, limited to the range 2..32, so `fsync` recurs every `cfg_slots`×`wl` bit periods.
- R4: `fsync` is high for exactly one bit period: the last bit of the last slot, just before bit 0 of slot 0.
- R5: With a continuous clock, `bclk` has a period of `cfg_div` system clocks (even, at least 2) and toggles even when no data is queued.
- R6: In gated mode (`cfg_gated`=1, `cfg_network`=0) `bclk` stays low while no word is queued. It toggles only during the frame-sync bit and the bits of a word taken from the holding register.
- R7: When `cfg_gated` and `cfg_network` are both 1, `cfg_error` is 1 and `bclk` runs continuously.
- R8: The word length `cfg_wlen` is limited to 8..24 bits. Transmit uses bits [wl-1:0] of `tx_data`, MSB first. `rx_data` carries the received word in bits [wl-1:0], with the upper bits zero.
- R9: In network mode, bit s of `cfg_slot_en` enables slot s. A disabled slot drives `sdout` low, does not consume the holding register, and produces no received word.
- R10: If the holding register is empty when an enabled slot starts, that slot sends zeros and `underrun` goes high. It stays high until reset.
- R11: `tx_ready` is high exactly when the holding register is empty. `rx_valid` stays high until `rx_ready` is seen.
- R12: While reset (`rst_n`, active low, synchronous) is held, `bclk`, `fsync`, `sdout`, `rx_valid` and `underrun` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_network | input | 1 | 1 = multi-slot framing |
| cfg_gated | input | 1 | 1 = request gated bit clock |
| cfg_wlen | input | 5 | Word length in bits (8..24) |
| cfg_slots | input | 6 | Slots per frame in network mode (2..32) |
| cfg_slot_en | input | 32 | Per-slot enable mask |
| cfg_div | input | 8 | System clocks per bit clock period |
| tx_data | input | 24 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 24 | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word accepted |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync pulse |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |
| cfg_error | output | 1 | Gated clock requested in network mode |
| underrun | output | 1 | Sticky empty-slot flag |

## Verification
The hardest situation to reach is gated mode, where the bit clock has to restart for a single word after a long silence. The frame-sync decision is made one bit ahead of the slot, so a word has to arrive in the right part of the idle frame. The stimulus offers exactly one word at a time and waits for it to go out. It then watches a quiet window for stray `bclk` edges before offering the next word. A serial model on the pins follows `fsync` to rebuild each slot, which covers continuous frames, random masks and slot counts up to 32.

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int WMAX = 24,
  parameter int SMAX = 32,
  parameter int DW   = 8,
  localparam int LW  = $clog2(WMAX + 1),
  localparam int SW  = $clog2(SMAX + 1),
  localparam int SIW = (SMAX > 1) ? $clog2(SMAX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_network,
  input  logic            cfg_gated,
  input  logic [LW-1:0]   cfg_wlen,
  input  logic [SW-1:0]   cfg_slots,
  input  logic [SMAX-1:0] cfg_slot_en,
  input  logic [DW-1:0]   cfg_div,
  input  logic [WMAX-1:0] tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [WMAX-1:0] rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            bclk,
  output logic            fsync,
  output logic            sdout,
  input  logic            sdin,
  output logic            cfg_error,
  output logic            underrun
);

  logic [DW-1:0]   cnt, half;
  logic            ph, fs, slot_on, gnext, hold_full, urun, rxv;
  logic [LW-1:0]   bit_idx, wl, wl_m1, nb, pad;
  logic [SW-1:0]   slot_idx, nsl, nsl_m1, ns;
  logic [WMAX-1:0] sh_tx, hold, rxd, lowmask;
  logic [WMAX-2:0] sh_rx;
  logic            gated, tick, last_bit, on_next;

  assign gated    = cfg_gated & ~cfg_network;
  assign wl       = (cfg_wlen < LW'(8)) ? LW'(8) : (cfg_wlen > LW'(WMAX)) ? LW'(WMAX) : cfg_wlen;
  assign nsl      = !cfg_network ? SW'(1) : (cfg_slots < SW'(2)) ? SW'(2) :
                    (cfg_slots > SW'(SMAX)) ? SW'(SMAX) : cfg_slots;
  assign half     = (cfg_div < DW'(2)) ? DW'(1) : {1'b0, cfg_div[DW-1:1]};
  assign tick     = (cnt == half - DW'(1));
  assign wl_m1    = wl - LW'(1);
  assign nsl_m1   = nsl - SW'(1);
  assign last_bit = (bit_idx == wl_m1);
  assign nb       = last_bit ? '0 : bit_idx + LW'(1);
  assign ns       = !last_bit ? slot_idx : (slot_idx == nsl_m1) ? '0 : slot_idx + SW'(1);
  assign on_next  = gated ? gnext : (!cfg_network || cfg_slot_en[ns[SIW-1:0]]);
  assign pad      = LW'(WMAX) - wl;
  assign lowmask  = {WMAX{1'b1}} >> pad;

  assign tx_ready  = ~hold_full;
  assign rx_data   = rxd;
  assign rx_valid  = rxv;
  assign fsync     = fs;
  assign sdout     = sh_tx[WMAX-1];
  assign bclk      = ph & (~gated | slot_on | fs);
  assign cfg_error = cfg_gated & cfg_network;
  assign underrun  = urun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      ph        <= 1'b0;
      bit_idx   <= wl - LW'(2);
      slot_idx  <= nsl_m1;
      fs        <= 1'b0;
      slot_on   <= 1'b0;
      gnext     <= 1'b0;
      sh_tx     <= '0;
      sh_rx     <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      rxd       <= '0;
      rxv       <= 1'b0;
      urun      <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + DW'(1);
      if (tx_valid && !hold_full) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end
      if (rxv && rx_ready) rxv <= 1'b0;
      if (tick) begin
        ph <= ~ph;
        if (!ph) begin
          bit_idx  <= nb;
          slot_idx <= ns;
          fs       <= (nb == wl_m1) && (ns == nsl_m1) && (!gated || hold_full);
          if ((nb == wl_m1) && (ns == nsl_m1)) gnext <= hold_full;
          if (last_bit) begin
            slot_on <= on_next;
            if (on_next && hold_full) begin
              sh_tx     <= hold << pad;
              hold_full <= 1'b0;
            end else begin
              sh_tx <= '0;
              if (on_next) urun <= 1'b1;
            end
          end else begin
            sh_tx <= sh_tx << 1;
          end
        end else if (slot_on) begin
          sh_rx <= {sh_rx[WMAX-3:0], sdin};
          if (last_bit) begin
            rxd <= {sh_rx, sdin} & lowmask;
            rxv <= 1'b1;
          end
        end
      end
    end
  end

  assert_fs_position_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fs |-> (bit_idx == wl_m1 && slot_idx == nsl_m1));
  assert_hold_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_full) |-> $past(tx_valid));
  assert_rx_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
  assert_quiet_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_on |-> !sdout);
  assert_net_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_network && ph) |-> bclk);
  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(urun) |-> urun);
  assert_divider_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph) |-> ($past(cnt) == $past(half) - DW'(1)));

endmodule

// File: tb/tdm_serial_port_test.sv
module tdm_serial_port_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_network = 1'b0, cfg_gated = 1'b0;
  logic [4:0]  cfg_wlen = 5'd8;
  logic [5:0]  cfg_slots = 6'd2;
  logic [31:0] cfg_slot_en = '0;
  logic [7:0]  cfg_div = 8'd2;
  logic [23:0] tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b1, sdin = 1'b0;
  logic        tx_ready, rx_valid, bclk, fsync, sdout, cfg_error, underrun;
  logic [23:0] rx_data;

  tdm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_network(cfg_network), .cfg_gated(cfg_gated),
    .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots), .cfg_slot_en(cfg_slot_en), .cfg_div(cfg_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .bclk(bclk), .fsync(fsync), .sdout(sdout), .sdin(sdin),
    .cfg_error(cfg_error), .underrun(underrun));

  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int wl_b = 8, ns_b = 1, div_b = 2;
  logic [31:0] mask_b = '0;
  bit net_b = 0, gated_b = 0, mon_en = 0, feed_forever = 0, acc_prev = 0;
  int feed_left = 0;
  logic [23:0] txq[$], rxq[$];
  bit b_on = 0, fs_seen = 0, exp_under = 0;
  int b_bit = 0, b_slot = 0, bits_since = 0, frames = 0, words_seen = 0, edges = 0;
  logic [23:0] cur_tx = '0, rx_word = '0;
  longint last_t = -1;

  function automatic logic [23:0] lmask(int w);
    return 24'hFFFFFF >> (24 - w);
  endfunction

  function automatic bit slot_en(int s);
    return net_b ? mask_b[s] : 1'b1;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setup(bit net, bit greq, int wl, int slots, logic [31:0] mask, int div, bit rdy);
    mon_en = 0;
    rst_n = 0;
    cfg_network = net; cfg_gated = greq; cfg_wlen = 5'(wl); cfg_slots = 6'(slots);
    cfg_slot_en = mask; cfg_div = 8'(div); rx_ready = rdy;
    net_b = net; gated_b = greq && !net; wl_b = wl; ns_b = net ? slots : 1;
    mask_b = mask; div_b = div;
    feed_forever = 0; feed_left = 0;
    txq.delete(); rxq.delete();
    b_on = 0; fs_seen = 0; exp_under = 0; b_bit = 0; b_slot = 0;
    bits_since = 0; frames = 0; words_seen = 0; last_t = -1;
    tx_data = 24'($urandom);
    repeat (4) @(posedge clk);
    #1 rst_n = 1; mon_en = 1;
  endtask

  task automatic run_frames(int n);
    while (frames < n) @(posedge clk);
  endtask

  // transmit-side driver
  always @(negedge clk) begin
    if (!rst_n) begin
      tx_valid = 0; acc_prev = 0;
    end else begin
      if (acc_prev) begin
        tx_data = 24'($urandom);
        if (feed_left > 0) feed_left--;
      end
      tx_valid = feed_forever || (feed_left > 0);
      acc_prev = tx_valid && tx_ready;
      if (acc_prev) txq.push_back(tx_data & lmask(wl_b));
    end
  end

  // pin-level model of the far end
  always @(negedge bclk) begin
    if (mon_en) begin
      bits_since++;
      if (b_on) begin
        cur_tx = {cur_tx[22:0], sdout};
        if (b_bit == wl_b - 1) begin
          if (slot_en(b_slot)) begin
            logic [23:0] e;
            if (txq.size() > 0) e = txq.pop_front();
            else begin e = '0; exp_under = 1; end
            check((cur_tx & lmask(wl_b)) == e, "R8 tx word", cur_tx & lmask(wl_b), e);
          end else begin
            check((cur_tx & lmask(wl_b)) == 0, "R9 disabled slot", cur_tx & lmask(wl_b), 0);
          end
          words_seen++;
          b_bit = 0;
          b_slot = (b_slot == ns_b - 1) ? 0 : b_slot + 1;
          if (gated_b) b_on = 0;
        end else b_bit++;
      end
      if (fsync) begin
        if (fs_seen && !gated_b) begin
          check(bits_since == ns_b * wl_b, net_b ? "R3 frame length" : "R2 frame length",
                bits_since, ns_b * wl_b);
          check(b_on && b_bit == 0 && b_slot == 0, "R4 sync position", b_bit, 0);
        end
        fs_seen = 1; bits_since = 0; frames++;
        b_on = 1; b_bit = 0; b_slot = 0;
      end
      if (b_on) begin
        if (b_bit == 0) begin
          rx_word = 24'($urandom) & lmask(wl_b);
          if (slot_en(b_slot)) rxq.push_back(rx_word);
        end
        sdin = rx_word[wl_b - 1 - b_bit];
      end
    end
  end

  always @(posedge bclk) begin
    edges++;
    if (mon_en && !gated_b) begin
      if (last_t >= 0)
        check(($time - last_t) == longint'(div_b * CLK_P), "R5 bclk period", $time - last_t, div_b * CLK_P);
      last_t = $time;
    end
  end

  // received-word checker
  always @(negedge clk) begin
    if (mon_en && rx_valid && rx_ready) begin
      logic [23:0] e;
      e = (rxq.size() > 0) ? rxq.pop_front() : 24'hDEAD;
      check(rx_data == e, "R1 rx word", rx_data, e);
    end
  end

  task automatic reset_check();
    mon_en = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!bclk && !fsync && !sdout, "R12 reset pins", {bclk, fsync, sdout}, 0);
    check(!rx_valid && !underrun, "R12 reset flags", {rx_valid, underrun}, 0);
    check(tx_ready, "R12 reset tx_ready", tx_ready, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    reset_check();

    // normal continuous, directed extremes
    setup(0, 0, 8, 1, '0, 2, 1);  feed_forever = 1; run_frames(8);
    check(underrun == exp_under, "R10 no underrun", underrun, exp_under);
    setup(0, 0, 24, 1, '0, 6, 1); feed_forever = 1; run_frames(6);
    check(underrun == exp_under, "R10 no underrun", underrun, exp_under);

    // normal continuous, random word length and divider
    for (int i = 0; i < 3; i++) begin
      setup(0, 0, 8 + int'($urandom % 17), 1, '0, 2 * (1 + int'($urandom % 4)), 1);
      feed_forever = 1; run_frames(6);
      check(underrun == exp_under, "R10 no underrun", underrun, exp_under);
    end

    // network mode, directed
    setup(1, 0, 16, 4, 32'hB, 4, 1);           feed_forever = 1; run_frames(4);
    setup(1, 0, 8, 32, 32'hA5C3_0F91, 2, 1);   feed_forever = 1; run_frames(3);
    setup(1, 0, 12, 2, 32'h3, 2, 1);           feed_forever = 1; run_frames(5);
    check(underrun == exp_under, "R10 no underrun", underrun, exp_under);

    // network mode, random slots and mask
    for (int i = 0; i < 3; i++) begin
      setup(1, 0, 8 + int'($urandom % 17), 2 + int'($urandom % 31), $urandom, 2, 1);
      feed_forever = 1; run_frames(3);
    end

    // gated clock in normal mode: single words separated by silence
    setup(0, 1, 10, 1, '0, 4, 1);
    for (int i = 0; i < 3; i++) begin
      int e0;
      @(posedge clk); #1 feed_left = 1;
      repeat (300) @(posedge clk);
      e0 = edges;
      repeat (100) @(posedge clk);
      check(edges == e0, "R6 idle clock", edges - e0, 0);
    end
    check(words_seen == 3, "R6 gated words", words_seen, 3);
    check(!cfg_error, "R7 no error in normal gated", cfg_error, 0);

    // gated requested with network mode
    setup(1, 1, 16, 3, 32'h5, 2, 1);
    feed_forever = 1;
    @(negedge clk);
    check(cfg_error, "R7 cfg_error", cfg_error, 1);
    run_frames(4);

    // underrun with receive back-pressure
    setup(0, 0, 8, 1, '0, 4, 0);
    run_frames(4);
    @(negedge clk);
    check(underrun && exp_under, "R10 underrun set", underrun, 1);
    repeat (50) @(posedge clk);
    @(negedge clk);
    check(underrun, "R10 underrun sticky", underrun, 1);
    check(rx_valid, "R11 rx held without ready", rx_valid, 1);
    check(tx_ready, "R11 tx_ready when empty", tx_ready, 1);
    reset_check();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule